// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block prepares the setup values that a polyphase scaling engine needs before it can resize one plane. On a start pulse it takes the plane's source width and height in unsigned 16.16 fixed point, its destination width and height as whole pixels, a rotation flag and a mask of the planes that ask for scaling. From these it derives the U16.16 upscale factor for each axis, the scaler's input and output sizes, the initial phase and the delta phase for each axis, and a flag that turns the edge enhancer on for strong enlargements.

All six divisions run one after another through a single shared restoring divider that makes one quotient bit per clock. Because of this the calculation always takes the same number of cycles. Requests that cannot be served skip the divider and answer at once. A mask with more than one plane, a zero destination size, or a source smaller than one pixel counts as an error. An empty mask means nothing is scaled.

Top module: `scaler_phase_calc`

## Requirements
- R1: After reset, busy, done, err, scale_en and enh_en are 0 and every size, factor and phase output is 0.
- R2: h_factor is (dst_w * 2^32) / src_w and v_factor is (dst_h * 2^32) / src_h, integer division, with src_w and src_h read as 16.16 values; the result is a U16.16 value in 32 bits.
- R3: With rotated = 0, in_w is src_w[31:16] and in_h is src_h[31:16]. With rotated = 1 the two are swapped. out_w equals dst_w and out_h equals dst_h.
- R4: h_init is ((in_w * 16) / out_w + 1) / 2 and v_init is ((in_h * 16) / out_h + 1) / 2, each division rounding down.
- R5: h_delta is (in_w * 65536) / out_w and v_delta is (in_h * 65536) / out_h, rounding down.
- R6: After a successful calculation, enh_en is 1 exactly when bits [31:16] of h_factor or of v_factor are 2 or more, and scale_en is 1.
- R7: A start with two or more bits set in req_mask sets err, clears scale_en and enh_en, and raises done in the cycle right after the edge that samples start. No division runs, and all size, factor and phase outputs keep their values.
- R8: A start with req_mask all zero clears err, scale_en and enh_en, and raises done in the cycle right after the sampling edge. No division runs, and all size, factor and phase outputs keep their values.
- R9: A start with exactly one mask bit set, but with dst_w or dst_h equal to 0, or with src_w or src_h below 0x10000, behaves as in R7 (err set, immediate done, outputs held).
- R10: A valid request keeps busy high and raises done for exactly one cycle, 6*(NUM_W+2) = 300 clock edges after the edge that sampled start, where NUM_W = DST_W + 2*FRAC_W. done never rises without a start.
- R11: While busy is high, start is ignored: it does not change the results and produces no extra done.
- R12: While idle without start, every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (sampled when idle) |
| req_mask | input | PLANES | One bit per plane that asks for scaling |
| rotated | input | 1 | Plane is turned by 90 or 270 degrees |
| src_w | input | SRC_W | Source width, 16.16 fixed point |
| src_h | input | SRC_W | Source height, 16.16 fixed point |
| dst_w | input | DST_W | Destination width in pixels |
| dst_h | input | DST_W | Destination height in pixels |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| scale_en | output | 1 | Scaling engine enabled by last request |
| h_factor | output | DST_W+FRAC_W | Horizontal upscale factor, U16.16 |
| v_factor | output | DST_W+FRAC_W | Vertical upscale factor, U16.16 |
| in_w | output | SRC_W-FRAC_W | Scaler input width |
| in_h | output | SRC_W-FRAC_W | Scaler input height |
| out_w | output | DST_W | Scaler output width |
| out_h | output | DST_W | Scaler output height |
| h_init | output | DST_W+FRAC_W | Horizontal initial phase |
| v_init | output | DST_W+FRAC_W | Vertical initial phase |
| h_delta | output | DST_W+FRAC_W | Horizontal phase step |
| v_delta | output | DST_W+FRAC_W | Vertical phase step |
| enh_en | output | 1 | Edge enhancer enable |

## Verification
The bench builds the block with its default parameters: four request bits, 32-bit 16.16 source sizes, 16-bit destination sizes and 4 + 12 phase bits. Sixteen destination bits let a one-pixel source reach a factor of 0xFFFF0000, the top of the result range, and a destination of one pixel reach a zero-order initial phase. The 48-step divisions keep each run to 300 cycles, so a bench can cover many runs with rotation, fractional source sizes, a factor just below the enhancer threshold, and both adjacent and spread-out double requests.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // Order of the divisions issued to the shared divider.
  typedef enum logic [2:0] {
    JOB_HFAC   = 3'd0,
    JOB_VFAC   = 3'd1,
    JOB_HINIT  = 3'd2,
    JOB_HDELTA = 3'd3,
    JOB_VINIT  = 3'd4,
    JOB_VDELTA = 3'd5
  } job_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

endpackage

// File: rtl/spc_divider.sv
// Restoring divider: one quotient bit per clock, NUM_W steps per division.
module spc_divider #(
  parameter int NUM_W = 48,
  parameter int DEN_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             valid,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_r;
  logic [DEN_W-1:0] rem_r;
  logic [DEN_W-1:0] den_r;
  logic [CNT_W-1:0] cnt_r;

  logic [DEN_W:0]   trial;
  logic [DEN_W-1:0] diff;
  logic             fits;

  always_comb begin
    trial = {rem_r, q_r[NUM_W-1]};
    fits  = (trial >= {1'b0, den_r});
    diff  = trial[DEN_W-1:0] - den_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
      den_r <= '0;
      cnt_r <= '0;
      valid <= 1'b0;
    end else if (go) begin
      q_r   <= num;
      den_r <= den;
      rem_r <= '0;
      cnt_r <= CNT_W'(NUM_W);
      valid <= 1'b0;
    end else if (cnt_r != '0) begin
      rem_r <= fits ? diff : trial[DEN_W-1:0];
      q_r   <= {q_r[NUM_W-2:0], fits};
      cnt_r <= cnt_r - CNT_W'(1);
      valid <= (cnt_r == CNT_W'(1));
    end else begin
      valid <= 1'b0;
    end
  end

  assign busy = (cnt_r != '0);
  assign quo  = q_r;

endmodule

// File: rtl/spc_arg_check.sv
// Classifies a request: empty mask, several planes, or unusable sizes.
module spc_arg_check #(
  parameter int PLANES = 4,
  parameter int SRC_W  = 32,
  parameter int FRAC_W = 16,
  parameter int DST_W  = 16
) (
  input  logic [PLANES-1:0] mask,
  input  logic [SRC_W-1:0]  src_w,
  input  logic [SRC_W-1:0]  src_h,
  input  logic [DST_W-1:0]  dst_w,
  input  logic [DST_W-1:0]  dst_h,
  output logic              none_req,
  output logic              multi_req,
  output logic              bad_size
);
  localparam logic [SRC_W-1:0] ONE_PIX = SRC_W'(1) << FRAC_W;

  logic [PLANES-1:0] seen;
  logic [PLANES-1:0] dup;

  assign seen[0] = mask[0];
  assign dup[0]  = 1'b0;

  // Prefix chain: a bit set after any earlier set bit marks a duplicate.
  for (genvar i = 1; i < PLANES; i++) begin : g_chain
    assign seen[i] = seen[i-1] | mask[i];
    assign dup[i]  = dup[i-1] | (seen[i-1] & mask[i]);
  end

  assign none_req  = ~seen[PLANES-1];
  assign multi_req = dup[PLANES-1];
  assign bad_size  = (dst_w == '0) || (dst_h == '0) ||
                     (src_w < ONE_PIX) || (src_h < ONE_PIX);

endmodule

// File: rtl/spc_operand_sel.sv
// Builds numerator and denominator for the division selected by job.
module spc_operand_sel
  import spc_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int FRAC_W  = 16,
  parameter int DST_W   = 16,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12
) (
  input  job_e                         job,
  input  logic [SRC_W-1:0]             s_w,
  input  logic [SRC_W-1:0]             s_h,
  input  logic [SRC_W-FRAC_W-1:0]      i_w,
  input  logic [SRC_W-FRAC_W-1:0]      i_h,
  input  logic [DST_W-1:0]             o_w,
  input  logic [DST_W-1:0]             o_h,
  output logic [DST_W+2*FRAC_W-1:0]    num,
  output logic [SRC_W-1:0]             den
);
  localparam int IN_W     = SRC_W - FRAC_W;
  localparam int NUM_W    = DST_W + 2 * FRAC_W;
  localparam int DEN_W    = SRC_W;
  localparam int PH_SHIFT = PH_BITS + PH_FRAC;

  // Destination size moved up by two fraction widths: U.FRAC_W quotient.
  function automatic logic [NUM_W-1:0] f_factor_num(input logic [DST_W-1:0] d);
    return {d, {(2 * FRAC_W){1'b0}}};
  endfunction

  function automatic logic [NUM_W-1:0] f_init_num(input logic [IN_W-1:0] v);
    return NUM_W'(v) << PH_BITS;
  endfunction

  function automatic logic [NUM_W-1:0] f_delta_num(input logic [IN_W-1:0] v);
    return NUM_W'(v) << PH_SHIFT;
  endfunction

  always_comb begin
    case (job)
      JOB_HFAC:   begin num = f_factor_num(o_w); den = s_w;           end
      JOB_VFAC:   begin num = f_factor_num(o_h); den = s_h;           end
      JOB_HINIT:  begin num = f_init_num(i_w);   den = DEN_W'(o_w);   end
      JOB_HDELTA: begin num = f_delta_num(i_w);  den = DEN_W'(o_w);   end
      JOB_VINIT:  begin num = f_init_num(i_h);   den = DEN_W'(o_h);   end
      JOB_VDELTA: begin num = f_delta_num(i_h);  den = DEN_W'(o_h);   end
      default:    begin num = '0;                den = DEN_W'(1);     end
    endcase
  end

endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import spc_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int SRC_W   = 32,
  parameter int FRAC_W  = 16,
  parameter int DST_W   = 16,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [PLANES-1:0]          req_mask,
  input  logic                       rotated,
  input  logic [SRC_W-1:0]           src_w,
  input  logic [SRC_W-1:0]           src_h,
  input  logic [DST_W-1:0]           dst_w,
  input  logic [DST_W-1:0]           dst_h,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic                       scale_en,
  output logic [DST_W+FRAC_W-1:0]    h_factor,
  output logic [DST_W+FRAC_W-1:0]    v_factor,
  output logic [SRC_W-FRAC_W-1:0]    in_w,
  output logic [SRC_W-FRAC_W-1:0]    in_h,
  output logic [DST_W-1:0]           out_w,
  output logic [DST_W-1:0]           out_h,
  output logic [DST_W+FRAC_W-1:0]    h_init,
  output logic [DST_W+FRAC_W-1:0]    v_init,
  output logic [DST_W+FRAC_W-1:0]    h_delta,
  output logic [DST_W+FRAC_W-1:0]    v_delta,
  output logic                       enh_en
);
  localparam int IN_W  = SRC_W - FRAC_W;
  localparam int RES_W = DST_W + FRAC_W;
  localparam int NUM_W = DST_W + 2 * FRAC_W;
  localparam int DEN_W = SRC_W;
  localparam int INT_W = RES_W - FRAC_W;

  // Rounded halving: (q + 1) / 2 without a wider adder.
  function automatic logic [RES_W-1:0] f_half_round(input logic [RES_W-1:0] q);
    return (q >> 1) + RES_W'(q[0]);
  endfunction

  // Enhancer threshold on the integer part of an upscale factor.
  function automatic logic f_enh(input logic [INT_W-1:0] ip);
    return ip >= INT_W'(2);
  endfunction

  st_e              st_r;
  job_e             job_r;
  logic [SRC_W-1:0] s_w_r;
  logic [SRC_W-1:0] s_h_r;

  // Named internal events, also observed by the bound checker.
  logic             div_go;
  logic             div_busy;
  logic             div_valid;
  logic [NUM_W-1:0] div_quo;
  logic [NUM_W-1:0] div_num;
  logic [DEN_W-1:0] div_den;
  logic [RES_W-1:0] quo_lo;
  logic             quo_hi_nz;
  logic             last_job;
  logic             none_req;
  logic             multi_req;
  logic             bad_size;
  logic             accept;

  assign quo_lo    = div_quo[RES_W-1:0];
  assign quo_hi_nz = |div_quo[NUM_W-1:RES_W];
  assign last_job  = (job_r == JOB_VDELTA);
  assign accept    = (st_r == ST_IDLE) && start;
  assign busy      = (st_r == ST_RUN);

  spc_arg_check #(
    .PLANES(PLANES), .SRC_W(SRC_W), .FRAC_W(FRAC_W), .DST_W(DST_W)
  ) u_args (
    .mask      (req_mask),
    .src_w     (src_w),
    .src_h     (src_h),
    .dst_w     (dst_w),
    .dst_h     (dst_h),
    .none_req  (none_req),
    .multi_req (multi_req),
    .bad_size  (bad_size)
  );

  spc_operand_sel #(
    .SRC_W(SRC_W), .FRAC_W(FRAC_W), .DST_W(DST_W),
    .PH_BITS(PH_BITS), .PH_FRAC(PH_FRAC)
  ) u_opsel (
    .job (job_r),
    .s_w (s_w_r),
    .s_h (s_h_r),
    .i_w (in_w),
    .i_h (in_h),
    .o_w (out_w),
    .o_h (out_h),
    .num (div_num),
    .den (div_den)
  );

  spc_divider #(
    .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .busy  (div_busy),
    .valid (div_valid),
    .quo   (div_quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_r     <= ST_IDLE;
      job_r    <= JOB_HFAC;
      s_w_r    <= '0;
      s_h_r    <= '0;
      div_go   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      scale_en <= 1'b0;
      enh_en   <= 1'b0;
      h_factor <= '0;
      v_factor <= '0;
      in_w     <= '0;
      in_h     <= '0;
      out_w    <= '0;
      out_h    <= '0;
      h_init   <= '0;
      v_init   <= '0;
      h_delta  <= '0;
      v_delta  <= '0;
    end else begin
      done   <= 1'b0;
      div_go <= 1'b0;
      case (st_r)
        ST_IDLE: begin
          if (accept) begin
            if (none_req) begin
              err      <= 1'b0;
              scale_en <= 1'b0;
              enh_en   <= 1'b0;
              done     <= 1'b1;
            end else if (multi_req || bad_size) begin
              err      <= 1'b1;
              scale_en <= 1'b0;
              enh_en   <= 1'b0;
              done     <= 1'b1;
            end else begin
              err    <= 1'b0;
              s_w_r  <= src_w;
              s_h_r  <= src_h;
              out_w  <= dst_w;
              out_h  <= dst_h;
              in_w   <= rotated ? src_h[SRC_W-1:FRAC_W] : src_w[SRC_W-1:FRAC_W];
              in_h   <= rotated ? src_w[SRC_W-1:FRAC_W] : src_h[SRC_W-1:FRAC_W];
              job_r  <= JOB_HFAC;
              div_go <= 1'b1;
              st_r   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (div_valid) begin
            case (job_r)
              JOB_HFAC:   h_factor <= quo_lo;
              JOB_VFAC:   v_factor <= quo_lo;
              JOB_HINIT:  h_init   <= f_half_round(quo_lo);
              JOB_HDELTA: h_delta  <= quo_lo;
              JOB_VINIT:  v_init   <= f_half_round(quo_lo);
              default:    v_delta  <= quo_lo;
            endcase
            if (last_job) begin
              st_r     <= ST_IDLE;
              done     <= 1'b1;
              scale_en <= 1'b1;
              enh_en   <= f_enh(h_factor[RES_W-1:FRAC_W]) ||
                          f_enh(v_factor[RES_W-1:FRAC_W]);
            end else begin
              job_r  <= job_e'(job_r + 3'd1);
              div_go <= 1'b1;
            end
          end
        end
        default: st_r <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int PLANES = 4,
  parameter int RES_W  = 32,
  parameter int IN_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [PLANES-1:0] req_mask,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              scale_en,
  input logic              enh_en,
  input logic [RES_W-1:0]  h_factor,
  input logic [RES_W-1:0]  v_delta,
  input logic [IN_W-1:0]   in_w,
  input logic              div_go,
  input logic              div_busy,
  input logic              div_valid,
  input logic              last_job,
  input logic              quo_hi_nz
);

  // R10: completion is a single-cycle pulse and ends the busy phase
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a new division is only launched into an idle divider
  p_go_idle_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

  // R2: the quotient handed to the result registers fits the result width
  p_res_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_valid |-> !quo_hi_nz);

  // R7: rejected request drops the scaler enables
  p_err_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!scale_en && !enh_en));

  // R6: enhancer only with an enabled scaler
  p_enh_needs_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enh_en |-> scale_en);

  // R7: several requesting planes give an immediate error completion
  p_multi_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ($countones(req_mask) > 1)) |=> (err && done && !busy));

  // R8: empty mask completes at once without an error
  p_empty_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (req_mask == '0)) |=> (!err && done && !busy && !scale_en));

  // R11: start cannot end a running calculation early
  p_keep_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(div_valid && last_job)) |=> busy);

  // R12: idle without start leaves results untouched
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(h_factor) && $stable(v_delta) && $stable(in_w)));

endmodule

bind scaler_phase_calc spc_checker #(
  .PLANES (PLANES),
  .RES_W  (DST_W + FRAC_W),
  .IN_W   (SRC_W - FRAC_W)
) u_spc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .req_mask  (req_mask),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .scale_en  (scale_en),
  .enh_en    (enh_en),
  .h_factor  (h_factor),
  .v_delta   (v_delta),
  .in_w      (in_w),
  .div_go    (div_go),
  .div_busy  (div_busy),
  .div_valid (div_valid),
  .last_job  (last_job),
  .quo_hi_nz (quo_hi_nz)
);

// File: tb/scaler_phase_calc_tb_top.sv
module scaler_phase_calc_tb_top;

  localparam int PLANES = 4;
  localparam int SRC_W  = 32;
  localparam int FRAC_W = 16;
  localparam int DST_W  = 16;
  localparam int RES_W  = DST_W + FRAC_W;
  localparam int IN_W   = SRC_W - FRAC_W;
  localparam longint CALC_LAT = 6 * (DST_W + 2 * FRAC_W + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [PLANES-1:0] req_mask = '0;
  logic              rotated = 1'b0;
  logic [SRC_W-1:0]  src_w = '0;
  logic [SRC_W-1:0]  src_h = '0;
  logic [DST_W-1:0]  dst_w = '0;
  logic [DST_W-1:0]  dst_h = '0;
  logic              busy, done, err, scale_en, enh_en;
  logic [RES_W-1:0]  h_factor, v_factor, h_init, v_init, h_delta, v_delta;
  logic [IN_W-1:0]   in_w, in_h;
  logic [DST_W-1:0]  out_w, out_h;

  always #10 clk = ~clk;  // 50 MHz

  scaler_phase_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
    .rotated(rotated), .src_w(src_w), .src_h(src_h), .dst_w(dst_w),
    .dst_h(dst_h), .busy(busy), .done(done), .err(err),
    .scale_en(scale_en), .h_factor(h_factor), .v_factor(v_factor),
    .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
    .h_init(h_init), .v_init(v_init), .h_delta(h_delta),
    .v_delta(v_delta), .enh_en(enh_en)
  );

  typedef struct {
    longint t0;
    longint lat;
    bit     calc;
    bit     err;
    bit     sc;
    bit     enh;
    longint hf, vf, iw, ih, ow, oh, hi, vi, hd, vd;
    string  tag;
  } exp_t;

  exp_t   sb_q[$];
  int     n_tests = 0;
  int     n_fail  = 0;
  longint cyc     = 0;

  // Model of held results
  longint m_hf = 0, m_vf = 0, m_iw = 0, m_ih = 0, m_ow = 0, m_oh = 0;
  longint m_hi = 0, m_vi = 0, m_hd = 0, m_vd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Monitor: pops one expected item per done pulse and compares.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        chk("R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        string fr;
        e  = sb_q.pop_front();
        fr = e.calc ? "" : "R12 ";
        chk(e.tag, "latency", cyc - e.t0, e.lat);
        chk(e.tag, "err", longint'(err), longint'(e.err));
        chk(e.calc ? "R6" : e.tag, "scale_en", longint'(scale_en), longint'(e.sc));
        chk(e.calc ? "R6" : e.tag, "enh_en", longint'(enh_en), longint'(e.enh));
        chk({fr, "R2"}, "h_factor", longint'(h_factor), e.hf);
        chk({fr, "R2"}, "v_factor", longint'(v_factor), e.vf);
        chk({fr, "R3"}, "in_w", longint'(in_w), e.iw);
        chk({fr, "R3"}, "in_h", longint'(in_h), e.ih);
        chk({fr, "R3"}, "out_w", longint'(out_w), e.ow);
        chk({fr, "R3"}, "out_h", longint'(out_h), e.oh);
        chk({fr, "R4"}, "h_init", longint'(h_init), e.hi);
        chk({fr, "R4"}, "v_init", longint'(v_init), e.vi);
        chk({fr, "R5"}, "h_delta", longint'(h_delta), e.hd);
        chk({fr, "R5"}, "v_delta", longint'(v_delta), e.vd);
      end
    end
  end

  // Driver: computes expected results, queues them, pulses start.
  task automatic run_job(input logic [PLANES-1:0] m, input bit rot,
                         input logic [SRC_W-1:0] sw, input logic [SRC_W-1:0] sh,
                         input logic [DST_W-1:0] dw, input logic [DST_W-1:0] dh,
                         input bit poke);
    exp_t   e;
    int     ones = 0;
    bit     bad;
    longint usw = longint'(sw), ush = longint'(sh);
    longint udw = longint'(dw), udh = longint'(dh);
    for (int i = 0; i < PLANES; i++) ones += int'(m[i]);
    bad = (dw == 0) || (dh == 0) || (usw < 65536) || (ush < 65536);
    e.calc = 1'b0; e.err = 1'b0; e.sc = 1'b0; e.enh = 1'b0; e.lat = 0;
    if (ones == 0) begin
      e.tag = "R8";
    end else if (ones > 1) begin
      e.tag = "R7"; e.err = 1'b1;
    end else if (bad) begin
      e.tag = "R9"; e.err = 1'b1;
    end else begin
      e.tag  = "R10";
      e.calc = 1'b1;
      e.sc   = 1'b1;
      e.lat  = CALC_LAT;
      m_hf = ((udw << 32) / usw) & 64'hFFFF_FFFF;
      m_vf = ((udh << 32) / ush) & 64'hFFFF_FFFF;
      m_iw = rot ? (ush >> 16) : (usw >> 16);
      m_ih = rot ? (usw >> 16) : (ush >> 16);
      m_ow = udw;
      m_oh = udh;
      m_hi = ((m_iw * 16) / m_ow + 1) / 2;
      m_vi = ((m_ih * 16) / m_oh + 1) / 2;
      m_hd = (m_iw * 65536) / m_ow;
      m_vd = (m_ih * 65536) / m_oh;
      e.enh = ((m_hf / 65536) >= 2) || ((m_vf / 65536) >= 2);
    end
    e.hf = m_hf; e.vf = m_vf; e.iw = m_iw; e.ih = m_ih; e.ow = m_ow;
    e.oh = m_oh; e.hi = m_hi; e.vi = m_vi; e.hd = m_hd; e.vd = m_vd;

    @(negedge clk);
    req_mask = m; rotated = rot; src_w = sw; src_h = sh; dst_w = dw; dst_h = dh;
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    e.t0 = cyc;
    sb_q.push_back(e);

    if (poke && e.calc) begin
      repeat (100) @(posedge clk);
      @(negedge clk);
      chk("R10", "busy mid-run", longint'(busy), 1);
      // R11: a start carrying an empty mask must be ignored while busy
      req_mask = '0; dst_w = '0; src_w = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11", "busy after ignored start", longint'(busy), 1);
    end

    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1", "busy", longint'(busy), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "err", longint'(err), 0);
    chk("R1", "scale_en", longint'(scale_en), 0);
    chk("R1", "enh_en", longint'(enh_en), 0);
    chk("R1", "h_factor", longint'(h_factor), 0);
    chk("R1", "in_w", longint'(in_w), 0);
    chk("R1", "v_delta", longint'(v_delta), 0);

    // Exact 2x upscale: enhancer on
    run_job(4'b0010, 1'b0, 32'd1920 << 16, 32'd1080 << 16, 16'd3840, 16'd2160, 1'b0);
    // Fractional source, rotated, downscale
    run_job(4'b1000, 1'b1, 32'h0280_8000, 32'd480 << 16, 16'd300, 16'd500, 1'b0);
    // R12: idle without start keeps results
    repeat (20) @(negedge clk);
    chk("R12", "h_delta held", longint'(h_delta), m_hd);
    chk("R12", "in_h held", longint'(in_h), m_ih);
    // Empty mask (R8), then multi-request (R7), adjacent and spread
    run_job(4'b0000, 1'b0, 32'd64 << 16, 32'd64 << 16, 16'd128, 16'd128, 1'b0);
    run_job(4'b0011, 1'b0, 32'd64 << 16, 32'd64 << 16, 16'd128, 16'd128, 1'b0);
    run_job(4'b1001, 1'b1, 32'd64 << 16, 32'd64 << 16, 16'd128, 16'd128, 1'b0);
    // R9: zero destination, sub-pixel source
    run_job(4'b0100, 1'b0, 32'd64 << 16, 32'd64 << 16, 16'd0, 16'd128, 1'b0);
    run_job(4'b0001, 1'b0, 32'd64 << 16, 32'h0000_FFFF, 16'd128, 16'd128, 1'b0);
    // One-pixel source to one pixel, and to the largest destination
    run_job(4'b0001, 1'b0, 32'h0001_0000, 32'h0001_0000, 16'd1, 16'd1, 1'b0);
    run_job(4'b0100, 1'b1, 32'h0001_0000, 32'h0001_0000, 16'd65535, 16'd65535, 1'b0);
    // Factor just under 2 on both axes: enhancer stays off (R6)
    run_job(4'b0010, 1'b0, 32'h0001_0001, 32'h0001_0001, 16'd2, 16'd2, 1'b0);
    // Vertical only crosses the threshold, with a start poked mid-run (R11)
    run_job(4'b1000, 1'b0, 32'd100 << 16, 32'h0032_4000, 16'd100, 16'd151, 1'b1);
    // Odd sizes with rotation
    run_job(4'b0100, 1'b1, 32'h02D0_3333, 32'h0500_C000, 16'd777, 16'd333, 1'b0);

    repeat (5) @(negedge clk);
    chk("R10", "no stray completion", longint'(sb_q.size()), 0);
    finish_tb();
  end

endmodule